// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous host and one asynchronous 128K x 8 static RAM. The host offers one transfer at a time over a valid/ready handshake: a direction bit, a 17-bit word address and, for a store, a data byte. The sequencer turns each accepted request into a timed series of control-pin levels. These pins are a low-active select, a high-active select, a low-active write strobe and a low-active output enable. The sequencer also owns the enable of the shared data bus drivers, which is exposed as separate out, in and drive-enable signals.

Every phase of a transfer lasts a whole number of system clocks. Each of these counts is derived from a nanosecond minimum by rounding up against the clock period, and each can also be overridden. A load returns its byte on a registered output with a one-cycle valid pulse. After every load, the output enable stays high for a turnaround window before the sequencer may drive the bus again. The address pins move only while the write strobe is inactive, and a store commits on the rising edge of the write strobe.

Top module: `sram_seq_ctrl`

## Requirements
- R1: In reset and whenever `req_ready` is high, the memory is in standby: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, and `rd_valid`=0.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the sequence is back in idle. For a store this lasts SETUP_CYC+WRITE_PULSE_CYC+1 cycles. For a load it lasts READ_ACCESS_CYC+1+TURNAROUND_CYC cycles.
- R3: A store (`req_write`=1) first drives the data for SETUP_CYC cycles with `mem_we_n`=1. It then holds `mem_we_n`=0 for exactly WRITE_PULSE_CYC cycles and ends with one release cycle at `mem_we_n`=1. Both selects are active and the data is driven and stable through all three phases, so the byte lands on the strobe's rising edge.
- R4: A load (`req_write`=0) holds both selects active, `mem_oe_n`=0 and `mem_we_n`=1 for exactly READ_ACCESS_CYC cycles, with `mem_dq_oe`=0 throughout. `mem_dq_in` is sampled on the last edge of that window.
- R5: `rd_data` carries the sampled byte and `rd_valid` is 1 for exactly one cycle, READ_ACCESS_CYC cycles after the accepting edge. `rd_data` keeps its value until the next load.
- R6: `mem_addr` takes the request address at acceptance and does not change while the sequence is busy. It never changes in a cycle where `mem_we_n` is 0 or has just risen.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After a load, `mem_oe_n` stays 1 for at least TURNAROUND_CYC+1 cycles before `mem_dq_oe` rises.
- R8: Phase counts default to ceil(ns / CLK_NS), with a minimum of 1. Elaboration rejects phase counts below 1, and it rejects a setup plus strobe length shorter than the data setup time.
- R9: While `req_ready` is 0, changes on `req_valid`, `req_addr` and `req_wdata` have no effect on the memory pins or on the data that is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host offers a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Store data |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| rd_data | output | 8 | Last loaded byte |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Low-active select |
| mem_ce | output | 1 | High-active select |
| mem_we_n | output | 1 | Low-active write strobe |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The bench runs at CLK_NS=4, which gives one setup cycle, a two-cycle strobe, a three-cycle access and a one-cycle turnaround. The accepting edge is taken as cycle zero. The read-valid pulse is due in the cycle after edge three. Ready is due back after edge four for a store and after edge five for a load. The bench drives and samples on falling edges and counts those edges from acceptance, so each result is compared in exactly the cycle in which it is due. It also counts strobe-low and enable-low cycles per transfer. A behavioural memory model in the bench flags address motion under an active strobe, bus contention, short strobes and short data setup.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WSTROBE,
      ST_WRELEASE,
      ST_RACCESS,
      ST_RSAMPLE,
      ST_TURN
   } seq_state_e;

   typedef struct packed {
      logic sel;        // both selects active
      logic wr_strobe;  // write strobe asserted
      logic rd_en;      // output enable asserted
      logic drive;      // controller drives data bus
   } pin_ctl_t;

   localparam pin_ctl_t PINS_STANDBY = '0;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic pin_ctl_t decode_pins(input seq_state_e s);
      pin_ctl_t p;
      p = PINS_STANDBY;
      case (s)
         ST_WSETUP:   begin p.sel = 1'b1; p.drive = 1'b1; end
         ST_WSTROBE:  begin p.sel = 1'b1; p.wr_strobe = 1'b1; p.drive = 1'b1; end
         ST_WRELEASE: begin p.sel = 1'b1; p.drive = 1'b1; end
         ST_RACCESS:  begin p.sel = 1'b1; p.rd_en = 1'b1; end
         default:     p = PINS_STANDBY;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int MAX_COUNT = 4,
   parameter int CNT_W     = $clog2(MAX_COUNT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_driver.sv
module sram_pin_driver
   import sram_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_e nxt_state,
   output pin_ctl_t   pins
);

   // Pins are registered from the next state so they leave flops glitch-free
   // and line up with the state register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins <= PINS_STANDBY;
      end else begin
         pins <= decode_pins(nxt_state);
      end
   end

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= capture;
         if (capture) begin
            rd_data <= dq_in;
         end
      end
   end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W          = 17,
   parameter int DATA_W          = 8,
   parameter int CLK_NS          = 10,
   parameter int SETUP_NS        = 2,
   parameter int WP_NS           = 7,
   parameter int DW_NS           = 6,
   parameter int ACC_NS          = 10,
   parameter int OHZ_NS          = 3,
   parameter int SETUP_CYC       = ns_to_cyc(SETUP_NS, CLK_NS),
   parameter int WRITE_PULSE_CYC = ns_to_cyc(WP_NS, CLK_NS),
   parameter int READ_ACCESS_CYC = ns_to_cyc(ACC_NS, CLK_NS),
   parameter int TURNAROUND_CYC  = ns_to_cyc(OHZ_NS, CLK_NS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int MAX_A     = (SETUP_CYC > WRITE_PULSE_CYC) ? SETUP_CYC : WRITE_PULSE_CYC;
   localparam int MAX_B     = (READ_ACCESS_CYC > TURNAROUND_CYC) ? READ_ACCESS_CYC : TURNAROUND_CYC;
   localparam int MAX_PHASE = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W     = $clog2(MAX_PHASE + 1);

   localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(WRITE_PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(READ_ACCESS_CYC - 1);
   localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURNAROUND_CYC - 1);

   // R8: elaboration-time parameter checks
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_seq_ctrl: address and data widths must be positive");
      end
      if (SETUP_CYC < 1 || WRITE_PULSE_CYC < 1 || READ_ACCESS_CYC < 1 || TURNAROUND_CYC < 1) begin : g_bad_phase
         $error("sram_seq_ctrl: every phase needs at least one clock");
      end
      if ((SETUP_CYC + WRITE_PULSE_CYC) * CLK_NS < DW_NS) begin : g_bad_setup
         $error("sram_seq_ctrl: data setup before strobe end is too short");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              phase_done;
   logic              accept;
   logic              capture;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   pin_ctl_t          pins;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign capture   = (state_q == ST_RACCESS) && phase_done;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WSETUP;
                  tmr_val = LD_SETUP;
               end else begin
                  state_d = ST_RACCESS;
                  tmr_val = LD_ACC;
               end
            end
         end
         ST_WSETUP: begin
            if (phase_done) begin
               state_d  = ST_WSTROBE;
               tmr_load = 1'b1;
               tmr_val  = LD_PULSE;
            end
         end
         ST_WSTROBE: begin
            if (phase_done) state_d = ST_WRELEASE;
         end
         ST_WRELEASE: state_d = ST_IDLE;
         ST_RACCESS: begin
            if (phase_done) state_d = ST_RSAMPLE;
         end
         ST_RSAMPLE: begin
            state_d  = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = LD_TURN;
         end
         ST_TURN: begin
            if (phase_done) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q <= req_addr;
            if (req_write) wdata_q <= req_wdata;
         end
      end
   end

   sram_phase_timer #(
      .MAX_COUNT (MAX_PHASE),
      .CNT_W     (CNT_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (phase_done)
   );

   sram_pin_driver i_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_state (state_d),
      .pins      (pins)
   );

   sram_read_capture #(
      .DATA_W (DATA_W)
   ) i_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .dq_in    (mem_dq_in),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign mem_ce     = pins.sel;
   assign mem_ce_n   = ~pins.sel;
   assign mem_we_n   = ~pins.wr_strobe;
   assign mem_oe_n   = ~pins.rd_en;
   assign mem_dq_oe  = pins.drive;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_ce,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   assert_standby_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_strobe_with_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && !mem_ce_n && mem_ce));

   assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

   assert_read_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_ce_n && mem_ce));

   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || !$past(mem_we_n)) |-> $stable(mem_addr));

   assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_drive_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> $past(mem_oe_n));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_ce     (mem_ce),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   // Cycle counts expected at CLK_NS=4, worked out from the rounding rule (R8)
   localparam int EXP_SU  = 1;   // ceil(2/4)
   localparam int EXP_WP  = 2;   // ceil(7/4)
   localparam int EXP_AA  = 3;   // ceil(10/4)
   localparam int EXP_TA  = 1;   // ceil(3/4)
   localparam int MIN_DS  = 2;   // ceil(6/4) data setup before strobe end
   localparam int NVEC    = 10;

   // vector: {write, addr[16:0], data[7:0]}
   localparam logic [25:0] VEC [NVEC] = '{
      {1'b1, 17'h00000, 8'hA5},
      {1'b1, 17'h1FFFF, 8'h3C},
      {1'b0, 17'h00000, 8'h00},
      {1'b0, 17'h1FFFF, 8'h00},
      {1'b1, 17'h00000, 8'h5A},
      {1'b0, 17'h00000, 8'h00},
      {1'b1, 17'h0AAAA, 8'h81},
      {1'b1, 17'h15555, 8'h7E},
      {1'b0, 17'h15555, 8'h00},
      {1'b0, 17'h0AAAA, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic [16:0] mem_addr;
   logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   int checks = 0;
   int failures = 0;
   int model_viol = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_seq_ctrl #(.CLK_NS(4)) i_sram_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   // ---------------- behavioural memory model ----------------
   logic [7:0]  mem_arr [int];
   logic [7:0]  ref_arr [int];
   logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
   logic [16:0] p_addr = '0;
   logic [7:0]  p_dout = '0;
   int          we_low_run = 0, ds_run = 0, oe_hi_run = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         automatic logic sel = !mem_ce_n && mem_ce;
         if (sel && !p_we_n && !mem_we_n && mem_addr != p_addr) begin
            model_viol++; $display("FAIL R6 model: address moved under strobe actual=%0h expected=%0h", mem_addr, p_addr);
         end
         if (mem_dq_oe && sel && !mem_oe_n && mem_we_n) begin
            model_viol++; $display("FAIL R7 model: bus contention actual=1 expected=0");
         end
         if (mem_dq_oe && !p_dq_oe && oe_hi_run < EXP_TA + 1) begin
            model_viol++; $display("FAIL R7 model: turnaround actual=%0d expected>=%0d", oe_hi_run, EXP_TA + 1);
         end
         ds_run     = (mem_dq_oe && (!p_dq_oe || mem_dq_out == p_dout)) ? ds_run + 1 : 0;
         if (!p_we_n && mem_we_n) begin
            if (we_low_run < EXP_WP) begin
               model_viol++; $display("FAIL R3 model: strobe width actual=%0d expected>=%0d", we_low_run, EXP_WP);
            end
            if (ds_run - 1 < MIN_DS) begin
               model_viol++; $display("FAIL R3 model: data setup actual=%0d expected>=%0d", ds_run - 1, MIN_DS);
            end
            mem_arr[int'(p_addr)] = p_dout;
         end
         we_low_run = (!mem_we_n && sel) ? we_low_run + 1 : 0;
         oe_hi_run  = mem_oe_n ? oe_hi_run + 1 : 0;
         if (sel && !mem_oe_n && mem_we_n)
            mem_dq_in = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 8'h00;
         else
            mem_dq_in = 8'hEE;
      end
      p_we_n  = mem_we_n;
      p_oe_n  = mem_oe_n;
      p_dq_oe = mem_dq_oe;
      p_addr  = mem_addr;
      p_dout  = mem_dq_out;
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_standby(input string req);
      chk(req, {27'd0, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe},
               {27'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0});
   endtask

   function automatic logic [7:0] ref_get(input logic [16:0] a);
      return ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : 8'h00;
   endfunction

   // One transfer; called at a falling edge with req_ready high.
   task automatic run_op(input logic wr, input logic [16:0] a, input logic [7:0] d);
      int ready_k = 0, rv_k = 0, we_cnt = 0, oe_cnt = 0, addr_bad = 0;
      logic [7:0] rv_data = '0;
      logic [7:0] exp_rd = ref_get(a);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      for (int k = 1; k < 60; k++) begin
         if (req_ready) begin
            ready_k = k;
            req_valid = 1'b0;
            break;
         end
         if (k == 1) chk("R2 ready low after accept", {31'd0, req_ready}, 32'd0);
         // R9: garbage offered while busy
         req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
         if (mem_addr != a) addr_bad++;
         if (!mem_we_n) we_cnt++;
         if (!mem_oe_n) oe_cnt++;
         if (rd_valid) begin
            if (rv_k != 0) rv_k = 99; else rv_k = k;
            rv_data = rd_data;
         end
         @(negedge clk);
      end
      chk("R6 R9 address held while busy", addr_bad, 0);
      if (wr) begin
         chk("R2 store busy length", ready_k, EXP_SU + EXP_WP + 2);
         chk("R3 strobe low cycles", we_cnt, EXP_WP);
         chk("R3 no output enable in store", oe_cnt, 0);
         chk("R5 no valid pulse in store", rv_k, 0);
         ref_arr[int'(a)] = d;
      end else begin
         chk("R2 load busy length", ready_k, EXP_AA + EXP_TA + 2);
         chk("R4 output enable cycles", oe_cnt, EXP_AA);
         chk("R4 no strobe in load", we_cnt, 0);
         chk("R5 valid pulse position", rv_k, EXP_AA + 1);
         chk("R5 loaded byte", rv_data, exp_rd);
      end
      chk_standby("R1 standby after transfer");
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      chk_standby("R1 pins in reset");
      chk("R1 ready/valid in reset", {30'd0, req_ready, rd_valid}, 32'd2);
      rst_n = 1'b1;

      // idle with no request: pins stay in standby
      repeat (4) begin
         @(negedge clk);
         chk_standby("R1 idle standby");
      end

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);
      end

      // R5: rd_data holds its value across a store
      held = rd_data;
      run_op(1'b1, 17'h00123, 8'hC3);
      chk("R5 rd_data held across store", rd_data, held);

      // back-to-back load then store on the same address (turnaround path)
      run_op(1'b0, 17'h00123, 8'h00);
      run_op(1'b1, 17'h00123, 8'h3C);
      run_op(1'b0, 17'h00123, 8'h00);

      // unwritten address reads model default 0
      run_op(1'b0, 17'h01000, 8'h00);

      // reset during an idle period keeps memory contents
      rst_n = 1'b0;
      @(negedge clk);
      chk_standby("R1 pins during second reset");
      chk("R1 rd_valid during second reset", {31'd0, rd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(1'b0, 17'h1FFFF, 8'h00);

      repeat (3) @(negedge clk);
      chk("R3 R6 R7 memory model violations", model_viol, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule